// File: doc/BRIEF.md
# Strobe-Framed Serial Byte Port

This block is the slave end of a four-wire synchronous link to a display controller. The wires are a serial clock, a serial data input, an active-low framing strobe, and an open-drain data return. The host pulls the strobe low to open a frame and then clocks bytes in, least-significant bit first. Data is taken on each rising serial-clock edge. The first whole byte of a frame is tagged as a command and every later byte as data. Each finished byte reaches downstream logic as a one-cycle pulse in the system clock domain.

For readback, downstream logic hands a byte to the block. The block then presents it one bit per falling serial-clock edge on the return line. It only ever pulls that line low or lets it go.

All three host lines pass through two-flop synchronizers, and their edges are found in the system clock domain. The receive controller has three states: `RX_IDLE` (strobe high), `RX_CMD` (frame open, first byte pending) and `RX_DATA` (frame open, later bytes). Its transitions are:
- `RX_IDLE`→`RX_CMD` on strobe fall.
- `RX_CMD`→`RX_DATA` on the eighth bit.
- `RX_CMD`/`RX_DATA`→`RX_IDLE` on strobe rise.

The readback controller also has three states: `TX_IDLE` (line released), `TX_ARMED` (byte loaded, waiting for the first falling edge) and `TX_SHIFT` (bits going out). Its transitions are:
- `TX_IDLE`→`TX_ARMED` on a load while the frame is open.
- `TX_ARMED`→`TX_SHIFT` on a falling edge.
- `TX_SHIFT`→`TX_IDLE` on the falling edge after the last bit.
- Any state→`TX_IDLE` on strobe rise.
- `TX_ARMED`/`TX_SHIFT`→`TX_ARMED` on a reload.

Top module: `strobe_serial_port`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_is_cmd_o`, `frame_abort_o` and `sdo_drive_low_o` are 0, and `rx_byte_o` is 0.
- R2: While a frame is open, each rising serial-clock edge takes one bit, least-significant first. The eighth bit puts the byte on `rx_byte_o` and raises `rx_valid_o` for exactly one system cycle.
- R3: The first byte completed after a strobe fall has `rx_is_cmd_o`=1 with its valid pulse. Later bytes in the same frame have `rx_is_cmd_o`=0. `rx_is_cmd_o` is never 1 without `rx_valid_o`.
- R4: While the strobe is high, serial-clock edges are ignored: no valid pulse, no abort, and no bits carried into the next frame.
- R5: A strobe rise with 1 to 7 bits of a byte received raises `frame_abort_o` for one cycle. No valid pulse occurs for that byte, and the next frame starts from bit 0.
- R6: A strobe rise with no partial byte pending (0 bits since the last byte or frame start) produces no abort pulse.
- R7: A `tx_load_i` pulse while the frame is open captures `tx_byte_i`. Each following falling serial-clock edge presents the next bit, bit 0 first: `sdo_drive_low_o`=1 for a 0 bit and 0 for a 1 bit.
- R8: The falling edge after the eighth readback bit releases the line (`sdo_drive_low_o`=0). The line stays released while no byte is pending.
- R9: A `tx_load_i` pulse while the strobe is high is ignored: later falling edges in the next frame leave the line released.
- R10: A strobe rise releases the line at once and drops any readback byte still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host (asynchronous, idles high) |
| sdin_i | input | 1 | Serial data from host |
| stb_ni | input | 1 | Active-low frame strobe from host |
| tx_byte_i | input | 8 | Byte to return to the host |
| tx_load_i | input | 1 | One-cycle pulse that captures `tx_byte_i` |
| rx_byte_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle pulse per completed byte |
| rx_is_cmd_o | output | 1 | Marks the byte in the current valid pulse as the frame's command |
| frame_abort_o | output | 1 | One-cycle pulse when a frame closes mid-byte |
| sdo_drive_low_o | output | 1 | Pull-down enable for the open-drain return line |

## Verification
The assertions assume the host is slow relative to the system clock. Every serial-clock phase lasts several system cycles. Data in is stable across each rising edge. The strobe never moves within a few cycles of a serial-clock edge, so no strobe edge and clock edge are detected in the same cycle. The stimulus keeps to this: serial-clock half periods are eight system cycles, data changes only just after a falling edge, and the strobe moves only after the serial clock has rested high for a full half period.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SSP_BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_CMD  = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= RST_VAL;
                else         chain_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= RST_VAL;
                else         chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ssp_rx_fsm.sv
module ssp_rx_fsm
    import ssp_pkg::*;
#(
    parameter int BYTE_W = SSP_BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_rise_i,
    input  logic              sdin_i,
    input  logic              stb_fall_i,
    input  logic              stb_rise_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              is_cmd_o,
    output logic              abort_o
);

    localparam int               CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] shifted;
    logic              framed;
    logic              byte_done;

    assign framed    = (state_q != RX_IDLE);
    assign shifted   = {sdin_i, shreg_q[BYTE_W-1:1]};
    assign byte_done = framed && sclk_rise_i && (cnt_q == LAST_BIT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (stb_fall_i) state_d = RX_CMD;
            RX_CMD: begin
                if (stb_rise_i)     state_d = RX_IDLE;
                else if (byte_done) state_d = RX_DATA;
            end
            RX_DATA: if (stb_rise_i) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RX_IDLE;
        else         state_q <= state_d;
    end

    // Datapath and output pulses
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            byte_o   <= '0;
            valid_o  <= 1'b0;
            is_cmd_o <= 1'b0;
            abort_o  <= 1'b0;
        end else begin
            valid_o  <= 1'b0;
            is_cmd_o <= 1'b0;
            abort_o  <= 1'b0;
            if (framed && stb_rise_i) begin
                abort_o <= (cnt_q != '0);
                cnt_q   <= '0;
            end else if (!framed && stb_fall_i) begin
                cnt_q <= '0;
            end else if (framed && sclk_rise_i) begin
                shreg_q <= shifted;
                if (cnt_q == LAST_BIT) begin
                    byte_o   <= shifted;
                    valid_o  <= 1'b1;
                    is_cmd_o <= (state_q == RX_CMD);
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ssp_tx_fsm.sv
module ssp_tx_fsm
    import ssp_pkg::*;
#(
    parameter int BYTE_W = SSP_BYTE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              framed_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              sclk_fall_i,
    input  logic              stb_rise_i,
    output logic              drive_low_o
);

    localparam int LEFT_W = $clog2(BYTE_W + 1);

    tx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [LEFT_W-1:0] left_q;
    logic              take;

    assign take = load_i && framed_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (take) state_d = TX_ARMED;
            TX_ARMED: begin
                if (stb_rise_i)       state_d = TX_IDLE;
                else if (take)        state_d = TX_ARMED;
                else if (sclk_fall_i) state_d = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (stb_rise_i)                          state_d = TX_IDLE;
                else if (take)                           state_d = TX_ARMED;
                else if (sclk_fall_i && left_q == '0)    state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= TX_IDLE;
        else         state_q <= state_d;
    end

    // Shift register and line enable
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shreg_q     <= '0;
            left_q      <= '0;
            drive_low_o <= 1'b0;
        end else if (stb_rise_i) begin
            left_q      <= '0;
            drive_low_o <= 1'b0;
        end else if (take) begin
            shreg_q     <= byte_i;
            left_q      <= LEFT_W'(BYTE_W);
            drive_low_o <= 1'b0;
        end else if (sclk_fall_i && state_q != TX_IDLE) begin
            if (left_q != '0) begin
                drive_low_o <= ~shreg_q[0];
                shreg_q     <= shreg_q >> 1;
                left_q      <= left_q - 1'b1;
            end else begin
                drive_low_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/strobe_serial_port.sv
module strobe_serial_port
    import ssp_pkg::*;
#(
    parameter int BYTE_W      = SSP_BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              stb_ni,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              rx_is_cmd_o,
    output logic              frame_abort_o,
    output logic              sdo_drive_low_o
);

    localparam logic [2:0] SYNC_RST = 3'b101; // strobe high, data low, clock high

    logic [2:0] sync_q;
    logic       s_sclk, s_sdin, s_stb;
    logic       sclk_q, stb_q;
    logic       sclk_rise, sclk_fall, stb_rise, stb_fall;

    ssp_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({stb_ni, sdin_i, sclk_i}),
        .q_o   (sync_q)
    );

    assign s_sclk = sync_q[0];
    assign s_sdin = sync_q[1];
    assign s_stb  = sync_q[2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sclk_q <= 1'b1;
            stb_q  <= 1'b1;
        end else begin
            sclk_q <= s_sclk;
            stb_q  <= s_stb;
        end
    end

    assign sclk_rise = s_sclk & ~sclk_q;
    assign sclk_fall = ~s_sclk & sclk_q;
    assign stb_rise  = s_stb & ~stb_q;
    assign stb_fall  = ~s_stb & stb_q;

    ssp_rx_fsm #(.BYTE_W(BYTE_W)) rx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sclk_rise_i(sclk_rise),
        .sdin_i     (s_sdin),
        .stb_fall_i (stb_fall),
        .stb_rise_i (stb_rise),
        .byte_o     (rx_byte_o),
        .valid_o    (rx_valid_o),
        .is_cmd_o   (rx_is_cmd_o),
        .abort_o    (frame_abort_o)
    );

    ssp_tx_fsm #(.BYTE_W(BYTE_W)) tx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .framed_i   (~s_stb),
        .load_i     (tx_load_i),
        .byte_i     (tx_byte_i),
        .sclk_fall_i(sclk_fall),
        .stb_rise_i (stb_rise),
        .drive_low_o(sdo_drive_low_o)
    );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic rx_valid_o,
    input logic rx_is_cmd_o,
    input logic frame_abort_o,
    input logic sdo_drive_low_o,
    input logic tx_load_i,
    input logic sclk_fall,
    input logic stb_rise,
    input logic stb_q,
    input logic s_stb
);

    p_valid_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);

    p_cmd_needs_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_is_cmd_o |-> rx_valid_o);

    p_no_byte_outside_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |-> $past(!s_stb));

    p_abort_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_abort_o |=> !frame_abort_o);

    p_abort_excludes_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_abort_o |-> !rx_valid_o);

    p_line_moves_on_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sdo_drive_low_o != $past(sdo_drive_low_o)) |-> $past(sclk_fall || stb_rise || tx_load_i));

    p_released_while_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_q && s_stb) |-> !sdo_drive_low_o);

endmodule

bind strobe_serial_port ssp_checker chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rx_valid_o     (rx_valid_o),
    .rx_is_cmd_o    (rx_is_cmd_o),
    .frame_abort_o  (frame_abort_o),
    .sdo_drive_low_o(sdo_drive_low_o),
    .tx_load_i      (tx_load_i),
    .sclk_fall      (sclk_fall),
    .stb_rise       (stb_rise),
    .stb_q          (stb_q),
    .s_stb          (s_stb)
);

// File: tb/strobe_serial_port_tb_top.sv
module strobe_serial_port_tb_top;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       sdin = 1'b0;
    logic       stb_n = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_is_cmd, frame_abort, drive_low;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int         n_valid = 0;
    int         n_abort = 0;
    logic [7:0] log_byte [8];
    logic       log_cmd  [8];
    bit         drive_seen = 1'b0;

    always #2 clk = ~clk;

    strobe_serial_port dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .sclk_i         (sclk),
        .sdin_i         (sdin),
        .stb_ni         (stb_n),
        .tx_byte_i      (tx_byte),
        .tx_load_i      (tx_load),
        .rx_byte_o      (rx_byte),
        .rx_valid_o     (rx_valid),
        .rx_is_cmd_o    (rx_is_cmd),
        .frame_abort_o  (frame_abort),
        .sdo_drive_low_o(drive_low)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (n_valid < 8) begin
                    log_byte[n_valid] <= rx_byte;
                    log_cmd[n_valid]  <= rx_is_cmd;
                end
                n_valid <= n_valid + 1;
            end
            if (frame_abort) n_abort <= n_abort + 1;
            if (drive_low) drive_seen <= 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        cyc(2);
        n_valid = 0;
        n_abort = 0;
        drive_seen = 1'b0;
        cyc(1);
    endtask

    task automatic open_frame();
        stb_n = 1'b0;
        cyc(HALF);
    endtask

    task automatic close_frame();
        stb_n = 1'b1;
        cyc(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdin = b[i];
            cyc(HALF);
            sclk = 1'b1;
            cyc(HALF);
        end
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_byte = b;
        tx_load = 1'b1;
        cyc(1);
        tx_load = 1'b0;
        cyc(2);
    endtask

    task automatic t_reset();
        chk("R1 valid", int'(rx_valid), 0);
        chk("R1 abort", int'(frame_abort), 0);
        chk("R1 drive", int'(drive_low), 0);
        chk("R1 byte", int'(rx_byte), 0);
        chk("R1 cmd", int'(rx_is_cmd), 0);
    endtask

    task automatic t_single_cmd();
        clear_log();
        open_frame();
        send_bits(8'h40, 8);
        cyc(HALF);
        close_frame();
        chk("R2 count", n_valid, 1);
        chk("R2 byte", int'(log_byte[0]), 'h40);
        chk("R3 cmd flag", int'(log_cmd[0]), 1);
        chk("R6 no abort at boundary", n_abort, 0);
    endtask

    task automatic t_multi_byte();
        clear_log();
        open_frame();
        send_bits(8'hC3, 8);
        send_bits(8'h5A, 8);
        send_bits(8'hA5, 8);
        cyc(HALF);
        close_frame();
        chk("R2 count", n_valid, 3);
        chk("R2 lsb first b0", int'(log_byte[0]), 'hC3);
        chk("R2 lsb first b1", int'(log_byte[1]), 'h5A);
        chk("R2 lsb first b2", int'(log_byte[2]), 'hA5);
        chk("R3 first is cmd", int'(log_cmd[0]), 1);
        chk("R3 second is data", int'(log_cmd[1]), 0);
        chk("R3 third is data", int'(log_cmd[2]), 0);
        chk("R6 no abort", n_abort, 0);
    endtask

    task automatic t_abort();
        clear_log();
        open_frame();
        send_bits(8'hFF, 3);
        close_frame();
        chk("R5 abort pulse", n_abort, 1);
        chk("R5 no valid", n_valid, 0);
        open_frame();
        send_bits(8'h3C, 8);
        cyc(HALF);
        close_frame();
        chk("R5 clean restart count", n_valid, 1);
        chk("R5 clean restart byte", int'(log_byte[0]), 'h3C);
        chk("R3 cmd after abort", int'(log_cmd[0]), 1);
    endtask

    task automatic t_abort_mid_data();
        clear_log();
        open_frame();
        send_bits(8'h11, 8);
        send_bits(8'h00, 7);
        close_frame();
        chk("R5 abort in data byte", n_abort, 1);
        chk("R5 only cmd valid", n_valid, 1);
    endtask

    task automatic t_ignore_idle();
        clear_log();
        send_bits(8'h81, 8);
        send_bits(8'h81, 3);
        cyc(HALF);
        chk("R4 no valid while high", n_valid, 0);
        chk("R4 no abort while high", n_abort, 0);
        open_frame();
        send_bits(8'h96, 8);
        cyc(HALF);
        close_frame();
        chk("R4 no carried bits", int'(log_byte[0]), 'h96);
        chk("R4 one byte", n_valid, 1);
    endtask

    task automatic t_readback(input logic [7:0] b);
        logic [7:0] got;
        clear_log();
        open_frame();
        send_bits(8'h42, 8);
        load_tx(b);
        chk("R8 released before shift", int'(drive_low), 0);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0;
            cyc(HALF);
            got[i] = ~drive_low;
            sclk = 1'b1;
            cyc(HALF);
        end
        chk("R7 readback value", int'(got), int'(b));
        sclk = 1'b0;
        cyc(HALF);
        chk("R8 released after last bit", int'(drive_low), 0);
        sclk = 1'b1;
        cyc(HALF);
        close_frame();
    endtask

    task automatic t_load_idle();
        clear_log();
        load_tx(8'h00);
        open_frame();
        drive_seen = 1'b0;
        send_bits(8'h00, 8);
        chk("R9 load ignored while high", int'(drive_seen), 0);
        close_frame();
    endtask

    task automatic t_release_on_close();
        clear_log();
        open_frame();
        load_tx(8'h00);
        send_bits(8'h00, 2);
        chk("R7 zero bit pulls low", int'(drive_low), 1);
        close_frame();
        chk("R10 released on close", int'(drive_low), 0);
        open_frame();
        drive_seen = 1'b0;
        send_bits(8'h00, 3);
        chk("R10 pending byte dropped", int'(drive_seen), 0);
        close_frame();
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(4);
        t_reset();
        t_single_cmd();
        t_multi_byte();
        t_abort();
        t_abort_mid_data();
        t_ignore_idle();
        t_readback(8'h96);
        t_readback(8'h5B);
        t_load_idle();
        t_release_on_close();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule